// File: doc/BRIEF.md
# I2C Write Target with Software-Released Clock Stretch

This block is the receive side of an I2C target. It watches the bus through a synchronizer running on one system clock and finds START and STOP conditions. It shifts in an address byte and checks it against an own-address input. When the address matches, it acknowledges in hardware. It then accepts data bytes from the bus controller.

After every byte it accepts, the block pulls SCL low at the falling edge of the ninth clock. It raises a one-cycle interrupt and keeps the clock stretched until software pulses a release strobe. Software can read the received byte and decide on the next acknowledge without any risk of an overrun. A byte on a foreign address, or a read request, gets no acknowledge, no interrupt and no stretch, and the block stays quiet until the next START.

Top module: `i2c_wait_target`

## Requirements
- R1: During and right after synchronous reset, `scl_oe`, `sda_oe`, `irq`, `addr_hit`, `ack_seen` and `rx_byte` are all 0.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle and clears `addr_hit`. A START (SDA falling while SCL is high) begins a new address byte.
- R3: Bytes are received MSB first. Bits 7..1 of the address byte are the address and bit 0 is the direction flag (0 = write). When the address equals `own_addr` and the flag is 0, the block drives SDA low for the whole ninth clock with no software action, and it sets `addr_hit`.
- R4: On a matching address, a one-cycle `irq` pulse is raised and `scl_oe` goes to 1 at the falling edge of the ninth clock.
- R5: On a mismatched address, or a matching address with the direction flag at 1, SDA stays released (NACK), `addr_hit` is 0, no `irq` is raised and SCL is never held. Later bytes are ignored until the next START.
- R6: After a data byte, SDA is driven low during the ninth clock only when `ack_en` is 1 at that time.
- R7: After every data byte, whether acknowledged or not, `rx_byte` takes the byte, `scl_oe` goes to 1 and a one-cycle `irq` is raised at the falling edge of the ninth clock.
- R8: `scl_oe` stays 1 until a cycle in which `wait_rel` is 1, and it is 0 from the next cycle on. `rx_byte` does not change while `scl_oe` is 1.
- R9: `ack_seen` holds the inverse of the SDA level sampled at the rising edge of the ninth clock of the most recent byte.
- R10: A repeated START in the middle of a byte discards the partial bits and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | ADDR_W | Address this target answers to |
| ack_en | input | 1 | Acknowledge data bytes when 1 |
| wait_rel | input | 1 | One-cycle strobe that ends the stretch |
| rx_byte | output | ADDR_W+1 | Last data byte received |
| irq | output | 1 | One-cycle pulse at the end of an accepted byte |
| addr_hit | output | 1 | Own address matched in the current transfer |
| ack_seen | output | 1 | ACK level seen on the ninth clock of the last byte |

## Verification
A wrong bit counter or a wrong phase state shows up at the ninth clock of the same byte. The acknowledge arrives on the wrong clock or not at all, `ack_seen` reads wrong, and the stretch and `irq` appear at the wrong edge or are missing. A stretch that is not released hangs the bus controller model at its next rising edge. A stretch on a foreign address shows up as an `irq` the scoreboard does not expect. A byte register loaded at the wrong time is caught when the scoreboard compares `rx_byte` at the interrupt, and again later in the same stretch.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;  // idle bus reads high
      else     pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_rise,
  input  logic              bit_in,
  output logic [DATA_W-1:0] shreg,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (bit_rise && cnt <= LAST) begin
      if (cnt < LAST) shreg <= {shreg[DATA_W-2:0], bit_in};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_wait_target.sv
module i2c_wait_target
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              wait_rel,
  output logic [ADDR_W:0]   rx_byte,
  output logic              irq,
  output logic              addr_hit,
  output logic              ack_seen
);
  localparam int DATA_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W + 1);

  logic [1:0] sync_out;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic       shift_clr, addr_match;
  tgt_state_e state;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .dout(sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  i2c_bus_events u_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign shift_clr = start_det | stop_det |
                     (state == ST_IDLE) | (state == ST_WAIT) | (state == ST_SKIP);

  i2c_byte_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .clr(shift_clr), .bit_rise(scl_rise),
    .bit_in(sda_s), .shreg(shreg), .cnt(cnt)
  );

  // write request to this target: address field equal, direction flag 0
  assign addr_match = (shreg[DATA_W-1:1] == own_addr) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      irq      <= 1'b0;
      rx_byte  <= '0;
      addr_hit <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        addr_hit <= 1'b0;
        sda_oe   <= 1'b0;
        scl_oe   <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_fall && cnt == CNT_ACK) begin
              // set up the acknowledge while SCL is low before the 9th clock
              if (state == ST_ADDR) begin
                addr_hit <= addr_match;
                sda_oe   <= addr_match;
              end else begin
                sda_oe <= ack_en;
              end
            end else if (scl_rise && cnt == CNT_ACK) begin
              ack_seen <= ~sda_s;
            end else if (scl_fall && cnt == CNT_END) begin
              sda_oe <= 1'b0;
              if (state == ST_DATA || addr_hit) begin
                scl_oe <= 1'b1;
                irq    <= 1'b1;
                state  <= ST_WAIT;
                if (state == ST_DATA) rx_byte <= shreg;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_WAIT: begin
            if (wait_rel) begin
              scl_oe <= 1'b0;
              state  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wait_target_chk.sv
module i2c_wait_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              irq,
  input logic              addr_hit,
  input logic              wait_rel,
  input logic [DATA_W-1:0] rx_byte
);
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);  // R4
  AST_IRQ_WITH_STRETCH: assert property (@(posedge clk) disable iff (rst)
    irq |-> scl_oe);  // R7
  AST_STRETCH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> addr_hit);  // R5
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !wait_rel) |=> scl_oe);  // R8
  AST_STRETCH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && wait_rel) |=> !scl_oe);  // R8
  AST_RX_STABLE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    scl_oe |=> $stable(rx_byte));  // R8
  AST_SDA_FREE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe);  // R7
endmodule

bind i2c_wait_target i2c_wait_target_chk #(.DATA_W(ADDR_W + 1)) u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .addr_hit(addr_hit), .wait_rel(wait_rel), .rx_byte(rx_byte)
);

// File: tb/test_i2c_wait_target.sv
`timescale 1ns/1ps
module test_i2c_wait_target;
  localparam int HALF = 20;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h3A;
  logic ack_en = 1'b1;
  logic wait_rel = 1'b0;
  logic scl_oe, sda_oe, irq, addr_hit, ack_seen;
  logic [7:0] rx_byte;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_q[$];  // {is_addr, byte}

  always #2.5 clk = ~clk;

  i2c_wait_target i_i2c_wait_target (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_en(ack_en),
    .wait_rel(wait_rel), .rx_byte(rx_byte), .irq(irq),
    .addr_hit(addr_hit), .ack_seen(ack_seen)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b;
    tick(HALF);
    scl_up();
    tick(HALF);
    m_scl = 1'b0;
    tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1;
    tick(HALF);
    scl_up();
    tick(HALF / 2);
    acked = !sda_bus;
    tick(HALF / 2);
    m_scl = 1'b0;
    tick(4);
  endtask

  task automatic start_cond();
    m_sda = 1'b1;
    tick(HALF);
    scl_up();
    tick(HALF);
    m_sda = 1'b0;
    tick(HALF);
    m_scl = 1'b0;
    tick(4);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0;
    tick(HALF);
    scl_up();
    tick(HALF);
    m_sda = 1'b1;
    tick(HALF);
  endtask

  // monitor: plays the software side, scoreboards every interrupt
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && irq) begin
        logic [8:0] item;
        logic [7:0] held;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected irq", 1, 0);
        end else begin
          item = exp_q.pop_front();
          if (item[8]) chk(addr_hit == 1'b1, "R4 addr_hit at irq", addr_hit, 1);
          else         chk(rx_byte == item[7:0], "R7 rx_byte at irq", rx_byte, item[7:0]);
        end
        chk(scl_oe == 1'b1, "R4/R7 stretch at irq", scl_oe, 1);
        held = rx_byte;
        tick(30);
        chk(scl_oe == 1'b1, "R8 stretch held", scl_oe, 1);
        chk(rx_byte == held, "R8 rx_byte stable", rx_byte, held);
        wait_rel = 1'b1;
        @(negedge clk);
        wait_rel = 1'b0;
        chk(scl_oe == 1'b0, "R8 released after strobe", scl_oe, 0);
      end
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired, bus hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit a;
    tick(10);
    chk({scl_oe, sda_oe, irq, addr_hit, ack_seen} == 5'b0, "R1 flags in reset",
        {scl_oe, sda_oe, irq, addr_hit, ack_seen}, 0);
    rst = 1'b0;
    tick(3);
    chk({scl_oe, sda_oe, irq, addr_hit, ack_seen} == 5'b0, "R1 flags after reset",
        {scl_oe, sda_oe, irq, addr_hit, ack_seen}, 0);
    chk(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 0);

    // matched write, one acked data byte, one nacked data byte
    start_cond();
    exp_q.push_back({1'b1, 8'h74});
    send_byte(8'h74, a);
    chk(a == 1'b1, "R3 address ack", a, 1);
    chk(addr_hit == 1'b1, "R3 addr_hit", addr_hit, 1);
    chk(ack_seen == 1'b1, "R9 ack_seen on address", ack_seen, 1);
    exp_q.push_back({1'b0, 8'hA5});
    send_byte(8'hA5, a);
    chk(a == 1'b1, "R6 data ack with ack_en=1", a, 1);
    ack_en = 1'b0;
    exp_q.push_back({1'b0, 8'h3C});
    send_byte(8'h3C, a);
    chk(a == 1'b0, "R6 data nack with ack_en=0", a, 0);
    chk(ack_seen == 1'b0, "R9 ack_seen after nack", ack_seen, 0);
    ack_en = 1'b1;
    stop_cond();
    chk(addr_hit == 1'b0, "R2 stop clears addr_hit", addr_hit, 0);

    // foreign address: no ack, no stretch, data ignored
    start_cond();
    send_byte(8'h22, a);
    chk(a == 1'b0, "R5 foreign address nack", a, 0);
    chk(addr_hit == 1'b0, "R5 addr_hit low", addr_hit, 0);
    chk(scl_oe == 1'b0, "R5 no stretch", scl_oe, 0);
    send_byte(8'h55, a);
    chk(a == 1'b0, "R5 data after foreign address ignored", a, 0);
    chk(scl_oe == 1'b0, "R5 no stretch on ignored data", scl_oe, 0);
    stop_cond();

    // own address with read flag
    start_cond();
    send_byte(8'h75, a);
    chk(a == 1'b0, "R5 read request nack", a, 0);
    chk(addr_hit == 1'b0, "R5 read request no hit", addr_hit, 0);
    stop_cond();

    // repeated start after foreign address, then mid-byte repeated start
    start_cond();
    send_byte(8'h22, a);
    chk(a == 1'b0, "R5 foreign before restart", a, 0);
    start_cond();
    exp_q.push_back({1'b1, 8'h74});
    send_byte(8'h74, a);
    chk(a == 1'b1, "R10 ack after repeated start", a, 1);
    exp_q.push_back({1'b0, 8'h81});
    send_byte(8'h81, a);
    chk(a == 1'b1, "R6 ack 0x81", a, 1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    start_cond();
    exp_q.push_back({1'b1, 8'h74});
    send_byte(8'h74, a);
    chk(a == 1'b1, "R10 partial byte discarded", a, 1);
    exp_q.push_back({1'b0, 8'h00});
    send_byte(8'h00, a);
    chk(a == 1'b1, "R7 zero byte acked", a, 1);
    stop_cond();

    // top address value, and a one-bit miss
    own_addr = 7'h7F;
    start_cond();
    send_byte(8'hFC, a);
    chk(a == 1'b0, "R5 one-bit address miss", a, 0);
    stop_cond();
    start_cond();
    exp_q.push_back({1'b1, 8'hFE});
    send_byte(8'hFE, a);
    chk(a == 1'b1, "R3 address 0x7F ack", a, 1);
    exp_q.push_back({1'b0, 8'hFF});
    send_byte(8'hFF, a);
    chk(a == 1'b1, "R6 ack 0xFF", a, 1);
    chk(ack_seen == 1'b1, "R9 ack_seen after ack", ack_seen, 1);
    stop_cond();
    chk(addr_hit == 1'b0, "R2 stop after second transfer", addr_hit, 0);

    tick(100);
    chk(exp_q.size() == 0, "R4/R7 all expected interrupts seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule